// File: doc/BRIEF.md
# User-Page Data Access Permission Checker

This block is one stage of a core's memory pipeline. It sits after address translation has produced the leaf page entry and decides whether the access may proceed. It bases that decision on the owner bit of that entry (set means the page belongs to user code), the current privilege mode, a machine-level override that lets machine-mode loads and stores run at a saved privilege, and a supervisor status bit that allows supervisor loads and stores to reach user pages. In this project that status bit is called the user-access bit.

Two further controls can move a supervisor data access down to user privilege. The first is a per-request "unprivileged" flag. The second is a mode input under which a set user-access bit means "check supervisor data accesses as user". In both cases the kernel can touch application buffers but still faults on its own pages. The block reports the effective privilege it used and a fault with a page-fault cause code. Both are registered alongside the request, so they travel with the access through the pipeline.

The user-access bit is held inside the block. It is written through a write port, and any access can see the new value with no fence.

Top module: `uperm_check`

## Requirements
- R1: When the effective privilege is supervisor, the user-access bit is 0 and translation is on, a load or store to a page whose owner bit is 1 faults.
- R2: When the effective privilege is supervisor and the user-access bit is 1 (user-only mode off), loads and stores reach pages with owner bit 1. Loads and stores to owner-bit-0 pages are also permitted.
- R3: When translation is off (`vm_on`=0), no access faults, whatever the privilege, owner bit or user-access bit.
- R4: For loads and stores, the effective privilege is `prev_priv` when `cur_priv` is machine (2'b11) and `data_priv_en`=1; otherwise it is `cur_priv`. Privilege encoding: 00 user, 01 supervisor, 11 machine, and 10 is treated as user. The user-access bit then applies to machine-mode accesses that run as supervisor. An access whose effective privilege is machine never faults.
- R5: At effective privilege user, any access to a page with owner bit 0 faults, whatever the user-access bit.
- R6: A load or store with `req_unpriv`=1 is checked at user privilege (`rsp_priv`=00). It therefore faults on owner-bit-0 pages even when issued from supervisor mode.
- R7: With `uacc_user_only`=1, a supervisor load or store is checked as user while the user-access bit is 1. It then reaches owner-bit-1 pages, faults on owner-bit-0 pages and reports `rsp_priv`=00. While the bit is 0, R1 holds unchanged.
- R8: Instruction fetch (`req_kind`=00) always uses `cur_priv`, and ignores `data_priv_en`, `req_unpriv`, `uacc_user_only` and the user-access bit. A supervisor fetch from an owner-bit-1 page faults even when the user-access bit is 1.
- R9: The results appear on the `rsp_*` outputs one clock edge after the request is sampled. `rsp_valid` follows `req_valid`. `rsp_cause` is 12 for a fetch fault, 13 for a load fault (`req_kind`=01) and 15 for a store fault (`req_kind`=10, or 11, which is treated as a store). It is 0 when there is no fault, and `rsp_fault` is 0 when `rsp_valid` is 0.
- R10: A write on `uacc_wr_en` updates the user-access bit (`uacc_q`) at the next edge. A request presented in the same cycle as the write, or in any later cycle, is checked with the new value.
- R11: With `HAS_SUPER`=0, the user-access bit reads 0 and writes to it are ignored. A machine access running as supervisor then faults on owner-bit-1 pages.
- R12: After reset, `rsp_valid`, `rsp_fault` and `uacc_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 store |
| req_unpriv | input | 1 | Check this load/store at user privilege |
| cur_priv | input | 2 | Current privilege mode |
| data_priv_en | input | 1 | Machine-mode data accesses use `prev_priv` |
| prev_priv | input | 2 | Saved privilege used when the override is on |
| vm_on | input | 1 | Page-based translation active |
| pte_user | input | 1 | Owner bit of the leaf page entry |
| uacc_user_only | input | 1 | User-access bit means "supervisor data as user" |
| uacc_wr_en | input | 1 | Write strobe for the user-access bit |
| uacc_wr_data | input | 1 | New user-access bit value |
| rsp_valid | output | 1 | Registered request valid |
| rsp_fault | output | 1 | Registered page fault |
| rsp_cause | output | CAUSE_W | Fault cause code, 0 if none |
| rsp_priv | output | 2 | Effective privilege used for the check |
| uacc_q | output | 1 | Stored user-access bit |

## Verification
Every check result is due exactly one rising edge after the request is sampled. The bench drives a request on a falling edge, and the next rising edge captures it. The bench then reads `rsp_*` at the following falling edge and drops `req_valid` there. A user-access write is read back on `uacc_q` at the falling edge after its capturing edge. A request issued in the same cycle as a write is judged against the new value, which tests the bypass directly. The build without supervisor support runs beside the main one on the same stimulus, so the two results can be compared in the same sampling window.

// File: rtl/uperm_pkg.sv
// Package: shared encodings for the user-page permission checker.
// Assumes privilege code 2'b10 is never legal and is folded to user.
package uperm_pkg;
    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_STX   = 2'b11
    } acc_e;

    localparam int unsigned CAUSE_FETCH_PF = 12;
    localparam int unsigned CAUSE_LOAD_PF  = 13;
    localparam int unsigned CAUSE_STORE_PF = 15;

    // Fold the reserved privilege code to user.
    function automatic priv_e norm_priv(input logic [1:0] p);
        return (p == PRIV_RSVD) ? PRIV_U : priv_e'(p);
    endfunction
endpackage

// File: rtl/uperm_uacc_state.sv
// Module: holds the user-access bit and forwards a same-cycle write.
// Assumes: without supervisor support the bit is tied to 0.
module uperm_uacc_state #(
    parameter bit HAS_SUPER = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_data,
    output logic uacc_now,
    output logic uacc_q
);
    generate
        if (HAS_SUPER) begin : g_super
            logic bit_q;

            // Store the user-access bit.
            always_ff @(posedge clk) begin
                if (!rst_n)     bit_q <= 1'b0;
                else if (wr_en) bit_q <= wr_data;
            end

            // A write in flight is already visible to the request beside it.
            always_comb begin
                uacc_now = wr_en ? wr_data : bit_q;
            end
            assign uacc_q = bit_q;

            assert_uacc_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (uacc_q == $past(wr_data)));
            assert_uacc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_en |=> $stable(uacc_q));
        end else begin : g_nosuper
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ wr_en ^ wr_data;
            assign uacc_now  = 1'b0;
            assign uacc_q    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/uperm_priv_resolve.sv
// Module: works out the privilege at which an access is checked, and
// whether the user-access bit counts for it. Purely combinational.
// Assumes fetches never use the data-only overrides.
module uperm_priv_resolve
    import uperm_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       unpriv,
    input  logic [1:0] cur_priv,
    input  logic       data_priv_en,
    input  logic [1:0] prev_priv,
    input  logic       uacc,
    input  logic       user_only,
    output logic [1:0] eff_priv,
    output logic       uacc_eff
);
    priv_e cur_n;
    priv_e prev_n;
    priv_e base;
    logic  is_data;

    // Pick the base privilege, then apply the lowering controls.
    always_comb begin
        cur_n   = norm_priv(cur_priv);
        prev_n  = norm_priv(prev_priv);
        is_data = (kind != ACC_FETCH);
        base    = (is_data && cur_n == PRIV_M && data_priv_en) ? prev_n : cur_n;
        if (is_data && unpriv)
            eff_priv = PRIV_U;
        else if (is_data && base == PRIV_S && uacc && user_only)
            eff_priv = PRIV_U;
        else
            eff_priv = base;
        uacc_eff = is_data & uacc;
    end
endmodule

// File: rtl/uperm_page_judge.sv
// Module: decides the page fault and its cause from the effective
// privilege and the owner bit. Purely combinational.
// Assumes machine-level accesses are never checked against the owner bit.
module uperm_page_judge
    import uperm_pkg::*;
#(
    parameter int unsigned CAUSE_W = 5
) (
    input  logic [1:0]         eff_priv,
    input  logic               uacc_eff,
    input  logic               vm_on,
    input  logic               pte_user,
    input  logic [1:0]         kind,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    logic hit;

    // Compare the owner bit with the effective privilege.
    always_comb begin
        unique case (priv_e'(eff_priv))
            PRIV_U:  hit = !pte_user;
            PRIV_S:  hit = pte_user && !uacc_eff;
            default: hit = 1'b0;
        endcase
        fault = vm_on && hit;
    end

    // Select the cause code for the access type.
    always_comb begin
        if (!fault)
            cause = '0;
        else begin
            unique case (acc_e'(kind))
                ACC_FETCH: cause = CAUSE_W'(CAUSE_FETCH_PF);
                ACC_LOAD:  cause = CAUSE_W'(CAUSE_LOAD_PF);
                default:   cause = CAUSE_W'(CAUSE_STORE_PF);
            endcase
        end
    end
endmodule

// File: rtl/uperm_check.sv
// Module: top of the user-page permission check stage. Resolves the
// effective privilege, judges the owner bit and registers the result
// together with the request. Assumes the translation result arrives
// in the same cycle as the request.
module uperm_check
    import uperm_pkg::*;
#(
    parameter bit          HAS_SUPER = 1'b1,
    parameter int unsigned CAUSE_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic               req_unpriv,
    input  logic [1:0]         cur_priv,
    input  logic               data_priv_en,
    input  logic [1:0]         prev_priv,
    input  logic               vm_on,
    input  logic               pte_user,
    input  logic               uacc_user_only,
    input  logic               uacc_wr_en,
    input  logic               uacc_wr_data,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause,
    output logic [1:0]         rsp_priv,
    output logic               uacc_q
);
    logic               uacc_now;
    logic [1:0]         eff_priv;
    logic               uacc_eff;
    logic               fault_c;
    logic [CAUSE_W-1:0] cause_c;

    uperm_uacc_state #(.HAS_SUPER(HAS_SUPER)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (uacc_wr_en),
        .wr_data  (uacc_wr_data),
        .uacc_now (uacc_now),
        .uacc_q   (uacc_q)
    );

    uperm_priv_resolve u_resolve (
        .kind         (req_kind),
        .unpriv       (req_unpriv),
        .cur_priv     (cur_priv),
        .data_priv_en (data_priv_en),
        .prev_priv    (prev_priv),
        .uacc         (uacc_now),
        .user_only    (uacc_user_only),
        .eff_priv     (eff_priv),
        .uacc_eff     (uacc_eff)
    );

    uperm_page_judge #(.CAUSE_W(CAUSE_W)) u_judge (
        .eff_priv (eff_priv),
        .uacc_eff (uacc_eff),
        .vm_on    (vm_on),
        .pte_user (pte_user),
        .kind     (req_kind),
        .fault    (fault_c),
        .cause    (cause_c)
    );

    // Register the verdict so it travels with the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_priv  <= PRIV_U;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && fault_c;
            rsp_cause <= req_valid ? cause_c : '0;
            rsp_priv  <= eff_priv;
        end
    end

    assert_bare_nofault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !vm_on) |=> !rsp_fault);
    assert_sup_upage_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vm_on && pte_user && req_kind != ACC_FETCH &&
         eff_priv == PRIV_S && !uacc_now) |=> rsp_fault);
    assert_user_page0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && vm_on && !pte_user && eff_priv == PRIV_U) |=> rsp_fault);
    assert_mach_nofault_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && eff_priv == PRIV_M) |=> !rsp_fault);
    assert_fetch_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_FETCH) |=> (rsp_priv == norm_priv($past(cur_priv))));
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_cause == '0));
    assert_cause_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause == CAUSE_W'(CAUSE_FETCH_PF) ||
                       rsp_cause == CAUSE_W'(CAUSE_LOAD_PF) ||
                       rsp_cause == CAUSE_W'(CAUSE_STORE_PF)));
endmodule

// File: tb/uperm_check_tb.sv
// Bench: directed scenarios, one task each, checked against values
// taken from the requirements. 50 MHz clock.
module uperm_check_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'b01;
    logic       req_unpriv = 1'b0;
    logic [1:0] cur_priv = 2'b01;
    logic       data_priv_en = 1'b0;
    logic [1:0] prev_priv = 2'b00;
    logic       vm_on = 1'b1;
    logic       pte_user = 1'b0;
    logic       uacc_user_only = 1'b0;
    logic       uacc_wr_en = 1'b0;
    logic       uacc_wr_data = 1'b0;
    logic       rsp_valid, rsp_fault, uacc_q;
    logic [4:0] rsp_cause;
    logic [1:0] rsp_priv;
    logic       n_valid, n_fault, n_uacc;
    logic [4:0] n_cause;
    logic [1:0] n_priv;
    int checks = 0;
    int errors = 0;

    localparam logic [1:0] U = 2'b00, S = 2'b01, M = 2'b11;
    localparam logic [1:0] FE = 2'b00, LD = 2'b01, ST = 2'b10;

    always #10 clk = ~clk;

    uperm_check #(.HAS_SUPER(1'b1), .CAUSE_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_unpriv(req_unpriv), .cur_priv(cur_priv), .data_priv_en(data_priv_en),
        .prev_priv(prev_priv), .vm_on(vm_on), .pte_user(pte_user),
        .uacc_user_only(uacc_user_only), .uacc_wr_en(uacc_wr_en),
        .uacc_wr_data(uacc_wr_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_priv(rsp_priv), .uacc_q(uacc_q));

    uperm_check #(.HAS_SUPER(1'b0), .CAUSE_W(5)) u_dut_nosup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_unpriv(req_unpriv), .cur_priv(cur_priv), .data_priv_en(data_priv_en),
        .prev_priv(prev_priv), .vm_on(vm_on), .pte_user(pte_user),
        .uacc_user_only(uacc_user_only), .uacc_wr_en(uacc_wr_en),
        .uacc_wr_data(uacc_wr_data), .rsp_valid(n_valid), .rsp_fault(n_fault),
        .rsp_cause(n_cause), .rsp_priv(n_priv), .uacc_q(n_uacc));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, read the verdict one edge later.
    task automatic access(input logic [1:0] k, input logic [1:0] cp, input logic ov,
                          input logic [1:0] pp, input logic unp, input logic uo,
                          input logic vm, input logic pu, input logic wen, input logic wd,
                          input logic exp_f, input logic [1:0] exp_p, input string req);
        int exp_c;
        @(negedge clk);
        req_kind = k; cur_priv = cp; data_priv_en = ov; prev_priv = pp;
        req_unpriv = unp; uacc_user_only = uo; vm_on = vm; pte_user = pu;
        uacc_wr_en = wen; uacc_wr_data = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; uacc_wr_en = 1'b0;
        exp_c = !exp_f ? 0 : (k == FE) ? 12 : (k == LD) ? 13 : 15;
        check({req, " valid"}, int'(rsp_valid), 1);
        check({req, " fault"}, int'(rsp_fault), int'(exp_f));
        check({req, " cause"}, int'(rsp_cause), exp_c);
        check({req, " priv"}, int'(rsp_priv), int'(exp_p));
    endtask

    task automatic set_uacc(input logic v);
        @(negedge clk);
        uacc_wr_en = 1'b1; uacc_wr_data = v;
        @(negedge clk);
        uacc_wr_en = 1'b0;
        check("R10 stored bit", int'(uacc_q), int'(v));
    endtask

    task automatic t_reset_r12();
        check("R12 valid after reset", int'(rsp_valid), 0);
        check("R12 fault after reset", int'(rsp_fault), 0);
        check("R12 bit after reset", int'(uacc_q), 0);
    endtask

    task automatic t_sup_clear_r1();
        access(LD, S, 0, U, 0, 0, 1, 1, 0, 0, 1, S, "R1 load");
        access(ST, S, 0, U, 0, 0, 1, 1, 0, 0, 1, S, "R1 store");
    endtask

    task automatic t_sup_set_r2();
        set_uacc(1'b1);
        access(LD, S, 0, U, 0, 0, 1, 1, 0, 0, 0, S, "R2 load user page");
        access(ST, S, 0, U, 0, 0, 1, 0, 0, 0, 0, S, "R2 store sup page");
    endtask

    task automatic t_fetch_r8();
        access(FE, S, 1, U, 1, 1, 1, 1, 0, 0, 1, S, "R8 sup fetch user page");
        access(FE, M, 1, U, 0, 0, 1, 0, 0, 0, 0, M, "R8 mach fetch ignores override");
    endtask

    task automatic t_user_only_r7();
        access(LD, S, 0, U, 0, 1, 1, 0, 0, 0, 1, U, "R7 sup page faults");
        access(LD, S, 0, U, 0, 1, 1, 1, 0, 0, 0, U, "R7 user page ok");
    endtask

    task automatic t_nosup_r11();
        check("R11 bit stays 0", int'(n_uacc), 0);
        access(LD, M, 1, S, 0, 0, 1, 1, 0, 0, 0, S, "R11 main instance");
        check("R11 no-super fault", int'(n_fault), 1);
    endtask

    task automatic t_same_cycle_r10();
        access(LD, S, 0, U, 0, 0, 1, 1, 1, 0, 1, S, "R10 same-cycle clear");
        check("R10 bit cleared", int'(uacc_q), 0);
    endtask

    task automatic t_bare_r3();
        access(LD, S, 0, U, 0, 0, 0, 1, 0, 0, 0, S, "R3 sup bare");
        access(ST, U, 0, U, 0, 0, 0, 0, 0, 0, 0, U, "R3 user bare");
    endtask

    task automatic t_user_r5();
        access(LD, U, 0, U, 0, 0, 1, 0, 0, 0, 1, U, "R5 user load bit0");
        set_uacc(1'b1);
        access(ST, U, 0, U, 0, 0, 1, 0, 0, 0, 1, U, "R5 user store bit1");
        access(2'b11, U, 0, U, 0, 0, 1, 0, 0, 0, 1, U, "R9 kind 11 as store");
    endtask

    task automatic t_override_r4();
        access(LD, M, 1, S, 0, 0, 1, 1, 0, 0, 0, S, "R4 mach-as-sup bit1");
        set_uacc(1'b0);
        access(LD, M, 1, S, 0, 0, 1, 1, 0, 0, 1, S, "R4 mach-as-sup bit0");
        access(ST, M, 1, U, 0, 0, 1, 0, 0, 0, 1, U, "R4 mach-as-user");
        access(LD, M, 0, S, 0, 0, 1, 1, 0, 0, 0, M, "R4 mach no override");
    endtask

    task automatic t_unpriv_r6();
        access(LD, S, 0, U, 1, 0, 1, 0, 0, 0, 1, U, "R6 unpriv sup page");
        access(ST, S, 0, U, 1, 0, 1, 1, 0, 0, 0, U, "R6 unpriv user page");
        access(LD, S, 0, U, 0, 1, 1, 1, 0, 0, 1, S, "R7 user-only with bit 0");
    endtask

    task automatic t_idle_r9();
        @(negedge clk);
        check("R9 idle valid", int'(rsp_valid), 0);
        check("R9 idle fault", int'(rsp_fault), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r12();
        t_sup_clear_r1();
        t_sup_set_r2();
        t_fetch_r8();
        t_user_only_r7();
        t_nosup_r11();
        t_same_cycle_r10();
        t_bare_r3();
        t_user_r5();
        t_override_r4();
        t_unpriv_r6();
        t_idle_r9();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule